// File: doc/BRIEF.md
# Audio Capture Engine

This block records an audio stream into a memory buffer. A clock-driven rate counter, reloaded from the frequency of the paired voice, decides when a sample is taken. Each sample comes from one of two sources: the mixer output or the paired input voice. In add mode the output of a second paired voice is summed into it. The sum is saturated to signed 16 bits and stored either whole or as its upper byte.

Samples are packed into 32-bit words, lowest lane first. Finished words wait in an eight-entry FIFO, and a simple request/ready port drains them to memory. Each word is written to the word-aligned destination address plus four times its word index. When the index reaches the programmed length, the engine either wraps to the start of the buffer or stops. A chip places one instance beside each voice pair it wants to record.

Top module: `snd_capture`

## Requirements
- R1: After reset, `busy` and `mem_req` are low.
- R2: A write to the control byte (`reg_sel`=0) with bit 7 set raises `busy` on the next cycle and restarts the rate counter, the packing lane and the word index. With bit 7 clear, the same write lowers `busy` on the next cycle.
- R3: The first sample is taken on the first cycle `busy` is high, when the 17-bit rate counter holds 0x10000. After each sample the counter reloads with `voice_freq` and then counts up by one per cycle, so samples are taken every 0x10000 - `voice_freq` + 1 cycles.
- R4: Control bit 1 selects the source: 0 takes `mix_in`, 1 takes `voice_in`.
- R5: Control bit 0 (add mode) adds `pair_in` to the selected source before conversion.
- R6: The sum is saturated to the range -32768..32767.
- R7: Control bit 3 selects the format. When it is 0, 16-bit samples fill bits 15:0 first and then bits 31:16, two per word. When it is 1, bits 15:8 of the saturated sample are stored as one byte, filling byte lanes 0 to 3 in order, four per word.
- R8: A word with index i is written to (`dst` with bits 1:0 cleared) + 4*i.
- R9: With control bit 2 clear, `busy` falls when the word with index `len`-1 is completed, so exactly `len` words are produced.
- R10: With control bit 2 set, the index wraps from `len`-1 to 0 and capture continues.
- R11: The FIFO holds up to 8 words in order while memory stalls. A word completed while the FIFO is full and nothing is popped is dropped, but it still consumes its index.
- R12: While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_addr` and `mem_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control byte, 1 destination, 2 length |
| reg_wdata | input | 32 | Register write data |
| voice_freq | input | 16 | Frequency of the paired voice (rate reload) |
| mix_in | input | 20 | Signed mixer output |
| voice_in | input | 20 | Signed output of the paired input voice |
| pair_in | input | 20 | Signed output of the voice added in add mode |
| busy | output | 1 | Capture running |
| mem_req | output | 1 | A word is waiting to be written |
| mem_rdy | input | 1 | Memory accepts the word this cycle |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 32 | Packed word |

## Verification
The bench sweeps all eight combinations of add mode, source select and format against sample streams that go past the 16-bit range in both directions. A converter that wraps instead of saturating, picks the wrong source, or drops the add term would corrupt specific lanes. Lane order and the byte taken in 8-bit mode are checked word by word, so packing a sample into the wrong half or byte shows up at once. An unaligned destination and a wrapping buffer catch address arithmetic that leaves out the alignment or the wrap to index zero. A long memory stall checks that exactly eight words survive, with their original indices, and that the pending request holds still. An off-by-one in the stop condition or the rate period changes the word count or which samples are taken.

// File: rtl/snd_cap_pkg.sv
package snd_cap_pkg;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;

    typedef enum logic {
        FMT_PCM16 = 1'b0,
        FMT_PCM8  = 1'b1
    } cap_fmt_e;

    typedef struct packed {
        logic     busy;
        cap_fmt_e fmt;
        logic     rpt;
        logic     src_voice;
        logic     add_en;
    } cap_ctrl_t;

    function automatic cap_ctrl_t decode_ctrl(input logic [7:0] b);
        cap_ctrl_t c;
        c.add_en    = b[0];
        c.src_voice = b[1];
        c.rpt       = b[2];
        c.fmt       = cap_fmt_e'(b[3]);
        c.busy      = b[7];
        return c;
    endfunction

endpackage

// File: rtl/snd_cap_rate.sv
module snd_cap_rate #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] freq,
    output logic             fire
);
    localparam logic [CNT_W:0] START = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic [CNT_W:0] cnt;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = run && st_q.cnt[CNT_W];
        if (restart) begin
            st_d.cnt = START;
        end else if (run) begin
            if (fire) st_d.cnt = {1'b0, freq};
            else      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: START};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/snd_cap_conv.sv
module snd_cap_conv #(
    parameter int SMP_W = 20
) (
    input  logic signed [SMP_W-1:0] mix_in,
    input  logic signed [SMP_W-1:0] voice_in,
    input  logic signed [SMP_W-1:0] pair_in,
    input  logic                    src_voice,
    input  logic                    add_en,
    output logic signed [15:0]      smp16
);
    localparam int SW = SMP_W + 1;
    localparam logic signed [SW-1:0] MAXV = SW'(32767);
    localparam logic signed [SW-1:0] MINV = -SW'(32768);

    logic signed [SW-1:0] src_x, add_x, sum;

    always_comb begin
        src_x = src_voice ? SW'(voice_in) : SW'(mix_in);
        add_x = add_en ? SW'(pair_in) : '0;
        sum   = src_x + add_x;
        if (sum > MAXV)      smp16 = 16'sh7fff;
        else if (sum < MINV) smp16 = -16'sh8000;
        else                 smp16 = sum[15:0];
    end
endmodule

// File: rtl/snd_cap_pack.sv
module snd_cap_pack
    import snd_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        in_valid,
    input  cap_fmt_e    fmt,
    input  logic [15:0] smp16,
    output logic        word_valid,
    output logic [31:0] word_data
);
    typedef struct packed {
        logic [31:0] acc;
        logic [1:0]  lane;
    } pack_st_t;

    pack_st_t    st_d, st_q;
    logic [31:0] merged;
    logic        last;

    always_comb begin
        st_d   = st_q;
        merged = st_q.acc;
        if (fmt == FMT_PCM8) begin
            merged[{st_q.lane, 3'b000} +: 8] = smp16[15:8];
            last = (st_q.lane == 2'd3);
        end else begin
            merged[{st_q.lane[0], 4'b0000} +: 16] = smp16;
            last = st_q.lane[0];
        end
        word_valid = in_valid && last && !restart;
        word_data  = merged;
        if (restart) begin
            st_d.lane = 2'd0;
        end else if (in_valid) begin
            st_d.acc  = merged;
            st_d.lane = last ? 2'd0 : st_q.lane + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/snd_cap_fifo.sv
module snd_cap_fifo #(
    parameter int DW    = 48,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic [DW-1:0] head_data
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic                     empty;
        logic                     full;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && !st_q.empty;
        do_push = push && (!st_q.full || do_pop);
        if (do_push) begin
            st_d.mem[st_q.tail] = push_data;
            st_d.tail           = st_q.tail + 1'b1;
        end
        if (do_pop) st_d.head = st_q.head + 1'b1;
        if (do_push && !do_pop) begin
            st_d.empty = 1'b0;
            st_d.full  = (PW'(st_q.tail + 1'b1) == st_q.head);
        end else if (do_pop && !do_push) begin
            st_d.full  = 1'b0;
            st_d.empty = (PW'(st_q.head + 1'b1) == st_q.tail);
        end
        empty     = st_q.empty;
        full      = st_q.full;
        head_data = st_q.mem[st_q.head];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/snd_capture.sv
module snd_capture
    import snd_cap_pkg::*;
#(
    parameter int SMP_W  = 20,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [31:0]             reg_wdata,
    input  logic [CNT_W-1:0]        voice_freq,
    input  logic signed [SMP_W-1:0] mix_in,
    input  logic signed [SMP_W-1:0] voice_in,
    input  logic signed [SMP_W-1:0] pair_in,
    output logic                    busy,
    output logic                    mem_req,
    input  logic                    mem_rdy,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [31:0]             mem_data
);
    localparam int EW = LEN_W + 32;

    typedef struct packed {
        cap_ctrl_t         ctrl;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              ctrl_wr, run, fire;
    logic signed [15:0] smp16;
    logic              word_valid;
    logic [31:0]       word_data;
    logic              f_empty, f_full;
    logic [EW-1:0]     head;
    logic [LEN_W-1:0]  head_idx;

    assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
    assign run     = st_q.ctrl.busy && !ctrl_wr;

    snd_cap_rate #(.CNT_W(CNT_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .run     (run),
        .freq    (voice_freq),
        .fire    (fire)
    );

    snd_cap_conv #(.SMP_W(SMP_W)) u_conv (
        .mix_in    (mix_in),
        .voice_in  (voice_in),
        .pair_in   (pair_in),
        .src_voice (st_q.ctrl.src_voice),
        .add_en    (st_q.ctrl.add_en),
        .smp16     (smp16)
    );

    snd_cap_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (ctrl_wr),
        .in_valid   (fire),
        .fmt        (st_q.ctrl.fmt),
        .smp16      (smp16),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    snd_cap_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (word_valid),
        .push_data ({st_q.idx, word_data}),
        .pop       (mem_rdy),
        .empty     (f_empty),
        .full      (f_full),
        .head_data (head)
    );

    always_comb begin
        st_d = st_q;
        if (word_valid) begin
            if (st_q.idx == st_q.len - LEN_W'(1)) begin
                st_d.idx = '0;
                if (!st_q.ctrl.rpt) st_d.ctrl.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + LEN_W'(1);
            end
        end
        if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    st_d.ctrl = decode_ctrl(reg_wdata[7:0]);
                    st_d.idx  = '0;
                end
                SEL_DST: st_d.dst = reg_wdata[ADDR_W-1:0];
                SEL_LEN: st_d.len = reg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx = head[EW-1:32];
    assign busy     = st_q.ctrl.busy;
    assign mem_req  = !f_empty;
    assign mem_data = head[31:0];
    assign mem_addr = {st_q.dst[ADDR_W-1:2], 2'b00} + ADDR_W'({head_idx, 2'b00});

    logic unused_full;
    assign unused_full = f_full;
endmodule

// File: rtl/snd_capture_chk.sv
module snd_capture_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_data
);
    // R2: start command raises busy
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0 && reg_wdata[7]) |=> busy);

    // R2: halt command lowers busy
    p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0 && !reg_wdata[7]) |=> !busy);

    // R2: busy never rises without a start command
    p_no_selfstart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(reg_we && reg_sel == 2'd0)) |=> !busy);

    // R12: stalled request holds
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    // R8: addresses are word aligned
    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

bind snd_capture snd_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
);

// File: tb/snd_capture_tb.sv
module snd_capture_tb;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_we = 1'b0;
    logic [1:0]         reg_sel = 2'd0;
    logic [31:0]        reg_wdata = '0;
    logic [15:0]        voice_freq = 16'hFFFC;
    logic signed [19:0] mix_in = '0, voice_in = '0, pair_in = '0;
    logic               busy, mem_req, mem_rdy = 1'b1;
    logic [31:0]        mem_addr, mem_data;

    int n_chk = 0, n_fail = 0, wr_total = 0;
    logic [31:0] got_addr [0:255];
    logic [31:0] got_data [0:255];

    always #5 clk = ~clk;

    snd_capture u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .voice_freq(voice_freq), .mix_in(mix_in),
        .voice_in(voice_in), .pair_in(pair_in), .busy(busy),
        .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always @(negedge clk) begin
        if (mem_req && mem_rdy && wr_total < 256) begin
            got_addr[wr_total] = mem_addr;
            got_data[wr_total] = mem_data;
            wr_total = wr_total + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int mixv(input int j);   return ((j * 7919) % 131072) - 65536; endfunction
    function automatic int voicev(input int j); return ((j * 313) % 40000) - 20000;   endfunction
    function automatic int pairv(input int j);  return ((j * 911) % 60000) - 30000;   endfunction

    function automatic logic [15:0] exp_s(input int j, input bit sv, input bit add);
        int s;
        s = (sv ? voicev(j) : mixv(j)) + (add ? pairv(j) : 0);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    function automatic logic [31:0] exp_word(input int w, input bit sv, input bit add,
                                             input bit f8, input int per);
        logic [31:0] wd;
        logic [15:0] s;
        int spw;
        wd = '0;
        spw = f8 ? 4 : 2;
        for (int l = 0; l < spw; l++) begin
            s = exp_s(1 + (w * spw + l) * per, sv, add);
            if (f8) wd[8*l +: 8] = s[15:8];
            else    wd[16*l +: 16] = s;
        end
        return wd;
    endfunction

    task automatic drive(input int j);
        mix_in   = 20'(mixv(j));
        voice_in = 20'(voicev(j));
        pair_in  = 20'(pairv(j));
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic run_capture(input logic [7:0] ctrl, input int ncyc);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = {24'd0, ctrl};
        @(posedge clk); #1;
        reg_we = 1'b0;
        drive(1);
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        for (int j = 1; j <= ncyc; j++) begin
            @(posedge clk); #1;
            drive(j + 1);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        logic [31:0] dst, a0, d0;
        #12;
        chk("R1 busy at reset", {31'd0, busy}, 32'd0);
        chk("R1 mem_req at reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R3 R4 R5 R6 R7 R8 R9: sweep of add/source/format, period 5
        for (int cfg = 0; cfg < 8; cfg++) begin
            dst = 32'h1000_0003 + 32'(cfg) * 32'h100;
            voice_freq = 16'hFFFC;
            reg_write(2'd1, dst);
            reg_write(2'd2, 32'd4);
            base = wr_total;
            run_capture({1'b1, 3'b000, cfg[2], 1'b0, cfg[1], cfg[0]}, 100);
            idle(20);
            chk("R9 busy after length", {31'd0, busy}, 32'd0);
            chk("R9 word count", 32'(wr_total - base), 32'd4);
            for (int w = 0; w < 4; w++) begin
                chk($sformatf("R3/R4/R5/R6/R7 cfg%0d word%0d", cfg, w), got_data[base + w],
                    exp_word(w, cfg[1], cfg[0], cfg[2], 5));
                chk($sformatf("R8 cfg%0d word%0d addr", cfg, w), got_addr[base + w],
                    (dst & ~32'h3) + 32'(4 * w));
            end
        end

        // R10: repeat with wrap, period 3, 16-bit, mixer
        dst = 32'h0000_2000;
        voice_freq = 16'hFFFE;
        reg_write(2'd1, dst);
        reg_write(2'd2, 32'd3);
        base = wr_total;
        run_capture(8'b1000_0100, 40);
        chk("R10 still busy in repeat", {31'd0, busy}, 32'd1);
        reg_write(2'd0, 32'd0);
        chk("R2 busy after halt", {31'd0, busy}, 32'd0);
        idle(10);
        chk("R10 word count", 32'(wr_total - base), 32'd7);
        for (int w = 0; w < 7; w++) begin
            chk($sformatf("R10 word%0d data", w), got_data[base + w], exp_word(w, 1'b0, 1'b0, 1'b0, 3));
            chk($sformatf("R10 word%0d addr", w), got_addr[base + w], dst + 32'(4 * (w % 3)));
        end

        // R11 R12: stall memory while 12 words are produced
        dst = 32'h0000_3000;
        voice_freq = 16'hFFFC;
        reg_write(2'd1, dst);
        reg_write(2'd2, 32'd12);
        idle(1);
        mem_rdy = 1'b0;
        base = wr_total;
        run_capture(8'b1000_0010, 130);
        chk("R9 busy after stalled run", {31'd0, busy}, 32'd0);
        chk("R11 request pending", {31'd0, mem_req}, 32'd1);
        a0 = mem_addr; d0 = mem_data;
        idle(3);
        chk("R12 addr held", mem_addr, a0);
        chk("R12 data held", mem_data, d0);
        mem_rdy = 1'b1;
        idle(20);
        chk("R11 surviving words", 32'(wr_total - base), 32'd8);
        for (int w = 0; w < 8; w++) begin
            chk($sformatf("R11 word%0d data", w), got_data[base + w], exp_word(w, 1'b1, 1'b0, 1'b0, 5));
            chk($sformatf("R11 word%0d addr", w), got_addr[base + w], dst + 32'(4 * w));
        end
        chk("R11 drained", {31'd0, mem_req}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule